// File: doc/BRIEF.md
# Three-Level Flying-Capacitor Leg Gate Selector

This block drives the four series switches of one phase leg in a three-level flying-capacitor converter. A level request asks for the upper rail, the midpoint or the lower rail. The upper and lower rails each have exactly one switch pattern. The midpoint can be built from two redundant patterns. One of them charges the leg's inner capacitor and the other discharges it, and which one does which depends on the direction of the phase current.

To choose between the two midpoint patterns, the block keeps a registered hysteresis flag. The flag comes from the difference between the measured inner capacitor voltage and half of the DC-link reference. It is set above a +1 V band edge, cleared below a −1 V band edge, and held in between. The flag is combined with the current direction so that the selected midpoint pattern pushes the capacitor back toward half the link voltage.

Gate outputs are registered and change only when a request is accepted. A converter uses three independent instances, one per phase.

Top module: `fcap_leg_select`

## Requirements
- R1: After reset the gate output `gates` is 0000 and stays 0000 until the first accepted level request.
- R2: Gate bits are ordered {S1,S2,S3,S4} from bit 3 down to bit 0, with S1 the outermost upper switch. An accepted request with `levelReq` = 2'b01 (upper rail) makes `gates` 1100 one clock later.
- R3: An accepted request with `levelReq` = 2'b11 (lower rail) makes `gates` 0011 one clock later.
- R4: An accepted request with `levelReq` = 2'b00 (midpoint) while `curPositive` = 1 yields 0101 when the hysteresis flag is set and 1010 when it is clear.
- R5: With `curPositive` = 0, the midpoint choice is inverted: a set flag yields 1010 and a clear flag yields 0101.
- R6: Voltages are signed, with 1 LSB = 1/16 V. The error is `capVolt` minus `dcRef` arithmetically shifted right by one (floor). An error strictly above +16 LSB sets the flag.
- R7: An error strictly below −16 LSB clears the flag. An error from −16 to +16 LSB inclusive leaves the flag unchanged.
- R8: The flag is updated on every clock, whether or not a request is present. A request accepted on the same edge as a flag update uses the flag value from before that edge.
- R9: `gates` changes only on an accepted request. Flag changes while any level is being held, midpoint included, leave `gates` unchanged.
- R10: A request carrying the reserved code 2'b10 is not accepted and leaves `gates` unchanged.
- R11: Reset clears the hysteresis flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| levelValid | input | 1 | A level request is present this cycle |
| levelReq | input | 2 | Requested level: 01 upper, 00 midpoint, 11 lower, 10 reserved |
| capVolt | input | VOLT_W | Measured inner capacitor voltage, signed, 1/16 V per LSB |
| dcRef | input | VOLT_W | DC-link voltage reference, signed, 1/16 V per LSB |
| curPositive | input | 1 | Phase current is in the reference direction |
| gates | output | 4 | Switch gate commands {S1,S2,S3,S4} |

## Verification
The bench drives the capacitor error to exactly ±16 and ±17 LSB. A design that puts the band edge on the wrong side would flip the flag inside the band, and a design that clears at zero instead of −1 V would flip on small negative errors. It also changes the flag and issues a midpoint request on the same edge; a design that bypasses the register would use the new flag one cycle early. Finally, it flips the flag and the current sign while the upper rail, or an earlier midpoint, is being held. An unregistered choice would then move the gates with no request present, and a reserved code that is wrongly accepted would alter the held pattern.

// File: rtl/fcleg_pkg.sv
`timescale 1ns/1ps
package fcleg_pkg;

  typedef enum logic [1:0] {
    LVL_MID   = 2'b00,
    LVL_UPPER = 2'b01,
    LVL_RSVD  = 2'b10,
    LVL_LOWER = 2'b11
  } level_e;

  localparam logic [3:0] PAT_OFF   = 4'b0000;
  localparam logic [3:0] PAT_UPPER = 4'b1100;
  localparam logic [3:0] PAT_LOWER = 4'b0011;
  localparam logic [3:0] PAT_MID_A = 4'b0101;
  localparam logic [3:0] PAT_MID_B = 4'b1010;

  typedef struct packed {
    logic   loadGates;
    logic   setHyst;
    logic   clrHyst;
    level_e level;
  } leg_strobe_t;

endpackage

// File: rtl/fcleg_datapath.sv
`timescale 1ns/1ps
module fcleg_datapath
  import fcleg_pkg::*;
#(
  parameter int VOLT_W   = 16,
  parameter int BAND_LSB = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  leg_strobe_t              strobe,
  input  logic signed [VOLT_W-1:0] capVolt,
  input  logic signed [VOLT_W-1:0] dcRef,
  input  logic                     curPositive,
  output logic                     aboveBand,
  output logic                     belowBand,
  output logic                     hystState,
  output logic [3:0]               gates
);

  localparam int ERR_W = VOLT_W + 2;
  localparam logic signed [ERR_W-1:0] BAND_POS = ERR_W'(BAND_LSB);
  localparam logic signed [ERR_W-1:0] BAND_NEG = -ERR_W'(BAND_LSB);

  logic signed [ERR_W-1:0] capExt;
  logic signed [ERR_W-1:0] refExt;
  logic signed [ERR_W-1:0] halfRef;
  logic signed [ERR_W-1:0] errVal;
  logic                    pickMidA;
  logic [3:0]              nextPattern;

  // error against half the link reference, with headroom for the subtraction
  assign capExt  = {{2{capVolt[VOLT_W-1]}}, capVolt};
  assign refExt  = {{2{dcRef[VOLT_W-1]}}, dcRef};
  assign halfRef = refExt >>> 1;
  assign errVal  = capExt - halfRef;

  assign aboveBand = errVal > BAND_POS;
  assign belowBand = errVal < BAND_NEG;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hystState <= 1'b0;
    end else if (strobe.setHyst) begin
      hystState <= 1'b1;
    end else if (strobe.clrHyst) begin
      hystState <= 1'b0;
    end
  end

  // a reversed current swaps the charging role of the two midpoint patterns
  assign pickMidA = (hystState == curPositive);

  always_comb begin
    unique case (strobe.level)
      LVL_UPPER: nextPattern = PAT_UPPER;
      LVL_LOWER: nextPattern = PAT_LOWER;
      LVL_MID:   nextPattern = pickMidA ? PAT_MID_A : PAT_MID_B;
      default:   nextPattern = gates;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gates <= PAT_OFF;
    end else if (strobe.loadGates) begin
      gates <= nextPattern;
    end
  end

endmodule

// File: rtl/fcleg_control.sv
`timescale 1ns/1ps
module fcleg_control
  import fcleg_pkg::*;
(
  input  logic        levelValid,
  input  logic [1:0]  levelReq,
  input  logic        aboveBand,
  input  logic        belowBand,
  output leg_strobe_t strobe
);

  level_e reqLevel;
  logic   reqLegal;

  assign reqLevel = level_e'(levelReq);
  assign reqLegal = (reqLevel != LVL_RSVD);

  always_comb begin
    strobe.loadGates = levelValid && reqLegal;
    strobe.setHyst   = aboveBand;
    strobe.clrHyst   = belowBand && !aboveBand;
    strobe.level     = reqLevel;
  end

endmodule

// File: rtl/fcap_leg_select.sv
`timescale 1ns/1ps
module fcap_leg_select
  import fcleg_pkg::*;
#(
  parameter int VOLT_W   = 16,
  parameter int BAND_LSB = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     levelValid,
  input  logic [1:0]               levelReq,
  input  logic signed [VOLT_W-1:0] capVolt,
  input  logic signed [VOLT_W-1:0] dcRef,
  input  logic                     curPositive,
  output logic [3:0]               gates
);

  leg_strobe_t strobe;
  logic        aboveBand;
  logic        belowBand;
  logic        hystState;

  fcleg_control i_control (
    .levelValid (levelValid),
    .levelReq   (levelReq),
    .aboveBand  (aboveBand),
    .belowBand  (belowBand),
    .strobe     (strobe)
  );

  fcleg_datapath #(
    .VOLT_W   (VOLT_W),
    .BAND_LSB (BAND_LSB)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .capVolt     (capVolt),
    .dcRef       (dcRef),
    .curPositive (curPositive),
    .aboveBand   (aboveBand),
    .belowBand   (belowBand),
    .hystState   (hystState),
    .gates       (gates)
  );

endmodule

// File: rtl/fcleg_checker.sv
`timescale 1ns/1ps
module fcleg_checker #(
  parameter int VOLT_W   = 16,
  parameter int BAND_LSB = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     levelValid,
  input logic [1:0]               levelReq,
  input logic signed [VOLT_W-1:0] capVolt,
  input logic signed [VOLT_W-1:0] dcRef,
  input logic                     hystState,
  input logic [3:0]               gates
);

  logic        seenLoad;
  logic        accepted;
  logic signed [31:0] chkErr;

  assign accepted = levelValid && (levelReq != 2'b10);
  assign chkErr   = 32'(capVolt) - (32'(dcRef) >>> 1);

  always_ff @(posedge clk) begin
    if (!rstN) seenLoad <= 1'b0;
    else if (accepted) seenLoad <= 1'b1;
  end

  // R1
  off_until_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenLoad |-> gates == 4'b0000);

  // R2
  upper_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelValid && levelReq == 2'b01) |=> gates == 4'b1100);

  // R3
  lower_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelValid && levelReq == 2'b11) |=> gates == 4'b0011);

  // R4
  mid_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelValid && levelReq == 2'b00) |=> (gates == 4'b0101 || gates == 4'b1010));

  // R6
  hyst_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkErr > BAND_LSB) |=> hystState);

  // R7
  hyst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkErr < -BAND_LSB) |=> !hystState);

  // R7
  hyst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chkErr >= -BAND_LSB && chkErr <= BAND_LSB) |=> $stable(hystState));

  // R9
  gates_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(gates));

endmodule

bind fcap_leg_select fcleg_checker #(
  .VOLT_W   (VOLT_W),
  .BAND_LSB (BAND_LSB)
) i_fcleg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .levelValid (levelValid),
  .levelReq   (levelReq),
  .capVolt    (capVolt),
  .dcRef      (dcRef),
  .hystState  (hystState),
  .gates      (gates)
);

// File: tb/test_fcap_leg_select.sv
`timescale 1ns/1ps
module test_fcap_leg_select;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               levelValid = 1'b0;
  logic [1:0]         levelReq = 2'b00;
  logic signed [15:0] capVolt = 16'sd5200;
  logic signed [15:0] dcRef = 16'sd10400;
  logic               curPositive = 1'b1;
  logic [3:0]         gates;

  int  checkCount = 0;
  int  failCount = 0;
  bit  expHyst = 1'b0;
  logic [3:0] expGates = 4'b0000;

  always #4 clk = ~clk;

  fcap_leg_select i_fcap_leg_select (
    .clk(clk), .rstN(rstN), .levelValid(levelValid), .levelReq(levelReq),
    .capVolt(capVolt), .dcRef(dcRef), .curPositive(curPositive), .gates(gates)
  );

  function automatic logic [3:0] modelPattern(logic [1:0] req, bit hyst, bit cur,
                                              logic [3:0] held);
    case (req)
      2'b01: return 4'b1100;
      2'b11: return 4'b0011;
      2'b00: return (hyst == cur) ? 4'b0101 : 4'b1010;
      default: return held;
    endcase
  endfunction

  function automatic bit modelHyst(int cap, int dc, bit hyst);
    int err;
    err = cap - (dc >>> 1);
    if (err > 16) return 1'b1;
    if (err < -16) return 1'b0;
    return hyst;
  endfunction

  task automatic checkGates(string tag);
    checkCount++;
    if (gates !== expGates) begin
      failCount++;
      $display("FAIL %s gates actual %b expected %b", tag, gates, expGates);
    end
  endtask

  // drive one cycle at the falling edge, advance the model, compare after the rising edge
  task automatic step(bit vld, logic [1:0] req, int cap, int dc, bit cur, string tag);
    logic [3:0] nextGates;
    bit nextHyst;
    levelValid  = vld;
    levelReq    = req;
    capVolt     = 16'(cap);
    dcRef       = 16'(dc);
    curPositive = cur;
    nextGates = (vld && req != 2'b10) ? modelPattern(req, expHyst, cur, expGates) : expGates;
    nextHyst  = modelHyst(cap, dc, expHyst);
    @(posedge clk);
    @(negedge clk);
    expGates = nextGates;
    expHyst  = nextHyst;
    checkGates(tag);
  endtask

  function automatic string autoTag(bit vld, logic [1:0] req, bit cur);
    if (!vld) return "R9";
    if (req == 2'b10) return "R10";
    if (req == 2'b01) return "R2";
    if (req == 2'b11) return "R3";
    return cur ? "R4" : "R5";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, then idle cycles keep gates off
    checkGates("R1");
    step(0, 2'b00, 5200, 10400, 1, "R1");
    step(1, 2'b10, 5200, 10400, 1, "R1");
    // R11: cleared flag with positive current gives 1010
    step(1, 2'b00, 5200, 10400, 1, "R11");
    step(1, 2'b01, 5200, 10400, 1, "R2");
    step(1, 2'b11, 5200, 10400, 1, "R3");
    // R7: error exactly +16 holds the cleared flag (odd ref floors to 5200)
    step(0, 2'b00, 5216, 10401, 1, "R7");
    step(1, 2'b00, 5200, 10400, 1, "R7");
    // R6: +17 sets the flag
    step(0, 2'b00, 5217, 10401, 1, "R6");
    step(1, 2'b00, 5200, 10400, 1, "R6");
    // R5: reversed current inverts the choice
    step(1, 2'b00, 5200, 10400, 0, "R5");
    // R7: -16 holds, -17 clears
    step(0, 2'b00, 5184, 10400, 1, "R7");
    step(1, 2'b00, 5200, 10400, 1, "R7");
    step(0, 2'b00, 5183, 10400, 1, "R7");
    step(1, 2'b00, 5200, 10400, 1, "R7");
    // R8: flag set on the same edge as a request: old flag used, new one next
    step(1, 2'b00, 5300, 10400, 1, "R8");
    step(1, 2'b00, 5200, 10400, 1, "R8");
    // R9: flag and current flips while upper level is held do not move gates
    step(1, 2'b01, 5000, 10400, 1, "R9");
    step(0, 2'b00, 5400, 10400, 0, "R9");
    step(0, 2'b00, 5000, 10400, 1, "R9");
    // R9: an earlier midpoint choice is held across flag changes
    step(1, 2'b00, 5200, 10400, 1, "R9");
    step(0, 2'b00, 5400, 10400, 1, "R9");
    step(0, 2'b00, 5400, 10400, 0, "R9");
    // R10: reserved code leaves the midpoint pattern in place
    step(1, 2'b10, 5200, 10400, 1, "R10");
    for (int i = 0; i < 3000; i++) begin
      bit vld;
      logic [1:0] req;
      int cap;
      int dc;
      bit cur;
      vld = ($urandom_range(0, 9) < 7);
      req = 2'($urandom_range(0, 3));
      dc  = 10400 + $urandom_range(0, 3) - 1;
      cap = (dc >>> 1) + $urandom_range(0, 60) - 30;
      cur = 1'($urandom_range(0, 1));
      step(vld, req, cap, dc, cur, autoTag(vld, req, cur));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule